// File: doc/BRIEF.md
# Shared-Ratio CIC Interpolator Bank

This block sits on the transmit side between a low-rate baseband source and a set of data converters. It accepts one or two complex (I/Q) channels through a valid/ready handshake, raises each real component to the converter clock rate with a fourth-order cascaded integrator-comb interpolator, and places each of the four resulting real streams on any of four converter lanes. The block does no frequency translation. That work, and the converter interface, belong to other logic.

A single ratio input sets the interpolation factor for every enabled channel, so all channels run at the same sample rate and share one slot counter. The transmit ratio has no link to any receive-side decimation setting. Changing the ratio restarts the whole bank from a cleared state, which keeps the enabled channels aligned to each other. A new output value is produced on every clock. A lane that no stream targets carries zero.

Top module: `cicx_tx_bank`

## Requirements
- R1: When `cfg_ratio` differs from the ratio held since the previous clock, `in_ready` is low in that cycle, and on the next edge every comb delay, stuffing register, integrator and the slot counter clear. All lanes therefore read zero in the following cycle.
- R2: With ratio R held, `in_ready[0]` is high exactly one cycle in every R. The first such cycle is the first cycle after reset or after a ratio restart.
- R3: `cfg_two_ch`=0 enables only channel 0. Then `in_ready[1]` stays low, channel 1's streams never reach a lane, and its filter state is held at zero.
- R4: A sample is taken only on a cycle with both valid and ready high. On a ready cycle with valid low, zero enters the comb section. Data offered while ready is low has no effect.
- R5: Each stream is four comb stages clocked on ready cycles, a stuffing register that holds the comb output for one cycle and zero on every other cycle, and four chained integrator registers. An isolated sample accepted at edge E appears unscaled on its lane after edge E+4, and the lane is zero before that edge.
- R6: A constant input offered in every slot settles to exactly the input times R³ on its lane.
- R7: Lane words are ACC_W = SMP_W + 4·RAT_W bits (28 by default), full precision, two's complement, sign-extended from the 12-bit signed inputs.
- R8: Stream index s is 0 = channel 0 I, 1 = channel 0 Q, 2 = channel 1 I, 3 = channel 1 Q. Stream s reaches lane `route_lane[s]` (2 bits) when `route_en[s]` is 1.
- R9: When several enabled streams target one lane, the lowest stream index drives it.
- R10: A lane that no enabled stream of an enabled channel targets outputs zero.
- R11: With two channels enabled, both ready signals are high in the same cycles.
- R12: A ratio of 0 behaves as a ratio of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rst | input | 1 | Synchronous active-high reset; loads the current ratio |
| cfg_ratio | input | 4 | Shared interpolation ratio (0 treated as 1) |
| cfg_two_ch | input | 1 | 1 enables channel 1 in addition to channel 0 |
| route_en | input | 4 | Per-stream routing enable |
| route_lane | input | 4x2 | Per-stream destination lane |
| in_valid | input | 2 | Per-channel sample valid |
| in_ready | output | 2 | Per-channel sample accept strobe |
| in_i | input | 2x12 | Per-channel signed I sample |
| in_q | input | 2x12 | Per-channel signed Q sample |
| lane_out | output | 4x28 | Converter lane words |

## Verification
The bench targets the impulse latency, because a design with one stage too many or too few would put the first nonzero word one edge late or early. It checks exact DC gain at ratios 3, 15 and 0. A wrong stuffing pattern or a ratio-0 divide slip shows up there as a scaled or ripple-carrying result. It changes the ratio mid-stream with state loaded, where a design that failed to clear would leak old integrator contents onto the lanes. It also drives lane collisions, unrouted lanes and a channel switched off while loaded, which would expose a wrong priority order or stale channel-1 data.

// File: rtl/cicx_pkg.sv
package cicx_pkg;

    parameter int CH_NUM   = 2;
    parameter int LANE_NUM = 4;
    parameter int SMP_W    = 12;
    parameter int RAT_W    = 4;
    parameter int STG      = 4;

    localparam int SRC_NUM = 2 * CH_NUM;
    localparam int ACC_W   = SMP_W + STG * RAT_W;
    localparam int LSEL_W  = $clog2(LANE_NUM);

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [SMP_W-1:0] smp_t;

    typedef enum logic {COMP_I = 1'b0, COMP_Q = 1'b1} comp_e;

    typedef struct packed {
        logic              en;
        logic [LSEL_W-1:0] lane;
    } route_t;

    function automatic logic [RAT_W-1:0] eff_ratio(input logic [RAT_W-1:0] r);
        return (r == '0) ? RAT_W'(1) : r;
    endfunction

    function automatic acc_t widen(input smp_t s);
        return acc_t'(s);
    endfunction

endpackage

// File: rtl/cicx_phase_ctl.sv
module cicx_phase_ctl
    import cicx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RAT_W-1:0] cfg_ratio,
    output logic             restart,
    output logic             load
);

    logic [RAT_W-1:0] ratio_q;
    logic [RAT_W-1:0] slot_q;
    logic [RAT_W-1:0] last_slot;

    always_comb begin
        last_slot = eff_ratio(ratio_q) - RAT_W'(1);
        restart   = (cfg_ratio != ratio_q);
        load      = (slot_q == '0) && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ratio_q <= cfg_ratio;
            slot_q  <= '0;
        end else if (slot_q == last_slot) begin
            slot_q  <= '0;
        end else begin
            slot_q  <= slot_q + RAT_W'(1);
        end
    end

endmodule

// File: rtl/cicx_path.sv
module cicx_path
    import cicx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    input  logic take,
    input  smp_t din,
    output acc_t dout
);

    acc_t dly_q [STG];
    acc_t ig_q  [STG];
    acc_t up_q;
    acc_t cmb   [STG+1];

    always_comb begin
        cmb[0] = take ? widen(din) : '0;
        for (int k = 0; k < STG; k++) begin
            cmb[k+1] = cmb[k] - dly_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int k = 0; k < STG; k++) begin
                dly_q[k] <= '0;
                ig_q[k]  <= '0;
            end
            up_q <= '0;
        end else begin
            for (int k = 0; k < STG; k++) begin
                if (load) dly_q[k] <= cmb[k];
            end
            up_q     <= load ? cmb[STG] : '0;
            ig_q[0]  <= ig_q[0] + up_q;
            for (int k = 1; k < STG; k++) begin
                ig_q[k] <= ig_q[k] + ig_q[k-1];
            end
        end
    end

    assign dout = ig_q[STG-1];

endmodule

// File: rtl/cicx_xbar.sv
module cicx_xbar
    import cicx_pkg::*;
(
    input  route_t [SRC_NUM-1:0]             route,
    input  logic   [SRC_NUM-1:0]             src_live,
    input  acc_t   [SRC_NUM-1:0]             src_val,
    output logic   [LANE_NUM-1:0][ACC_W-1:0] lane_out
);

    for (genvar gl = 0; gl < LANE_NUM; gl++) begin : g_lane
        acc_t pick;
        always_comb begin
            pick = '0;
            for (int s = SRC_NUM - 1; s >= 0; s--) begin
                if (src_live[s] && route[s].en && route[s].lane == LSEL_W'(gl)) begin
                    pick = src_val[s];
                end
            end
        end
        assign lane_out[gl] = pick;
    end

endmodule

// File: rtl/cicx_tx_bank.sv
module cicx_tx_bank
    import cicx_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [RAT_W-1:0]                 cfg_ratio,
    input  logic                             cfg_two_ch,
    input  logic [SRC_NUM-1:0]               route_en,
    input  logic [SRC_NUM-1:0][LSEL_W-1:0]   route_lane,
    input  logic [CH_NUM-1:0]                in_valid,
    output logic [CH_NUM-1:0]                in_ready,
    input  logic [CH_NUM-1:0][SMP_W-1:0]     in_i,
    input  logic [CH_NUM-1:0][SMP_W-1:0]     in_q,
    output logic [LANE_NUM-1:0][ACC_W-1:0]   lane_out
);

    logic                  restart;
    logic                  load;
    logic   [CH_NUM-1:0]   ch_en;
    logic   [SRC_NUM-1:0]  src_live;
    acc_t   [SRC_NUM-1:0]  src_val;
    route_t [SRC_NUM-1:0]  route;

    cicx_phase_ctl u_phase (
        .clk       (clk),
        .rst       (rst),
        .cfg_ratio (cfg_ratio),
        .restart   (restart),
        .load      (load)
    );

    for (genvar gc = 0; gc < CH_NUM; gc++) begin : g_ch
        if (gc == 0) begin : g_base
            assign ch_en[gc] = 1'b1;
        end else begin : g_opt
            assign ch_en[gc] = cfg_two_ch;
        end
        assign in_ready[gc] = load && ch_en[gc];
    end

    for (genvar gs = 0; gs < SRC_NUM; gs++) begin : g_src
        localparam int    CH   = gs / 2;
        localparam comp_e KIND = comp_e'(gs % 2);
        smp_t din;
        assign din          = (KIND == COMP_Q) ? smp_t'(in_q[CH]) : smp_t'(in_i[CH]);
        assign src_live[gs] = ch_en[CH];
        assign route[gs]    = '{en: route_en[gs], lane: route_lane[gs]};

        cicx_path u_path (
            .clk   (clk),
            .rst   (rst),
            .clear (restart || !ch_en[CH]),
            .load  (load),
            .take  (in_valid[CH] && in_ready[CH]),
            .din   (din),
            .dout  (src_val[gs])
        );
    end

    cicx_xbar u_xbar (
        .route    (route),
        .src_live (src_live),
        .src_val  (src_val),
        .lane_out (lane_out)
    );

endmodule

// File: rtl/cicx_tx_bank_chk.sv
module cicx_tx_bank_chk
    import cicx_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic [RAT_W-1:0]               cfg_ratio,
    input logic                           cfg_two_ch,
    input logic [SRC_NUM-1:0]             route_en,
    input logic [CH_NUM-1:0]              in_ready,
    input logic [LANE_NUM-1:0][ACC_W-1:0] lane_out
);

    assert_restart_blocks_ready_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_ratio) |-> in_ready == '0);

    assert_restart_clears_lanes_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_ratio) |=> lane_out == '0);

    assert_ready_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (in_ready[0] && cfg_ratio > RAT_W'(1)) |=> !in_ready[0]);

    assert_single_channel_R3: assert property (@(posedge clk) disable iff (rst)
        !cfg_two_ch |-> !in_ready[1]);

    assert_unrouted_zero_R10: assert property (@(posedge clk) disable iff (rst)
        route_en == '0 |-> lane_out == '0);

    assert_shared_slot_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_two_ch |-> in_ready[1] == in_ready[0]);

endmodule

bind cicx_tx_bank cicx_tx_bank_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_ratio  (cfg_ratio),
    .cfg_two_ch (cfg_two_ch),
    .route_en   (route_en),
    .in_ready   (in_ready),
    .lane_out   (lane_out)
);

// File: tb/cicx_tx_bank_tb_top.sv
module cicx_tx_bank_tb_top;
    import cicx_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                             clk = 1'b0;
    logic                             rst;
    logic [RAT_W-1:0]                 cfg_ratio;
    logic                             cfg_two_ch;
    logic [SRC_NUM-1:0]               route_en;
    logic [SRC_NUM-1:0][LSEL_W-1:0]   route_lane;
    logic [CH_NUM-1:0]                in_valid;
    logic [CH_NUM-1:0]                in_ready;
    logic [CH_NUM-1:0][SMP_W-1:0]     in_i;
    logic [CH_NUM-1:0][SMP_W-1:0]     in_q;
    logic [LANE_NUM-1:0][ACC_W-1:0]   lane_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    cicx_tx_bank dut_i (
        .clk (clk), .rst (rst), .cfg_ratio (cfg_ratio), .cfg_two_ch (cfg_two_ch),
        .route_en (route_en), .route_lane (route_lane), .in_valid (in_valid),
        .in_ready (in_ready), .in_i (in_i), .in_q (in_q), .lane_out (lane_out)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [CH_NUM-1:0] rdy_seen;

    // reference model state
    acc_t             m_dly [SRC_NUM][STG];
    acc_t             m_ig  [SRC_NUM][STG];
    acc_t             m_up  [SRC_NUM];
    int               m_slot;
    logic [RAT_W-1:0] m_rq;

    // scoreboard queues
    logic [LANE_NUM-1:0][ACC_W-1:0] exp_lanes_q [$];
    logic [CH_NUM-1:0]              exp_rdy_q   [$];
    string                          exp_tag_q   [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SRC_NUM; s++) begin
            m_up[s] = '0;
            for (int k = 0; k < STG; k++) begin
                m_dly[s][k] = '0;
                m_ig[s][k]  = '0;
            end
        end
        m_slot = 0;
        m_rq   = cfg_ratio;
    endtask

    task automatic model_cycle(input string tag);
        logic [LANE_NUM-1:0][ACC_W-1:0] lv;
        logic [CH_NUM-1:0] rv;
        logic [CH_NUM-1:0] en;
        bit rs, ld, found;
        int reff;
        acc_t x, c, t;
        rs   = (cfg_ratio != m_rq);
        reff = (m_rq == 0) ? 1 : int'(m_rq);
        ld   = (m_slot == 0) && !rs;
        for (int ch = 0; ch < CH_NUM; ch++) begin
            en[ch] = (ch == 0) || cfg_two_ch;
            rv[ch] = ld && en[ch];
        end
        for (int l = 0; l < LANE_NUM; l++) begin
            lv[l] = '0;
            found = 1'b0;
            for (int s = 0; s < SRC_NUM; s++) begin
                if (!found && route_en[s] && int'(route_lane[s]) == l && en[s/2]) begin
                    lv[l] = m_ig[s][STG-1];
                    found = 1'b1;
                end
            end
        end
        exp_lanes_q.push_back(lv);
        exp_rdy_q.push_back(rv);
        exp_tag_q.push_back(tag);
        if (rs) begin
            model_clear();
        end else begin
            for (int s = 0; s < SRC_NUM; s++) begin
                x = '0;
                if (in_valid[s/2] && rv[s/2])
                    x = acc_t'(smp_t'((s % 2 == 1) ? in_q[s/2] : in_i[s/2]));
                c = x;
                for (int k = 0; k < STG; k++) begin
                    t = c - m_dly[s][k];
                    if (ld) m_dly[s][k] = c;
                    c = t;
                end
                for (int k = STG - 1; k >= 1; k--) m_ig[s][k] = m_ig[s][k] + m_ig[s][k-1];
                m_ig[s][0] = m_ig[s][0] + m_up[s];
                m_up[s] = ld ? c : '0;
                if (!en[s/2]) begin
                    m_up[s] = '0;
                    for (int k = 0; k < STG; k++) begin
                        m_dly[s][k] = '0;
                        m_ig[s][k]  = '0;
                    end
                end
            end
            m_slot = (m_slot == reff - 1) ? 0 : m_slot + 1;
        end
    endtask

    // driver: sets inputs, records ready, pushes expected values, advances one clock
    task automatic tick(input logic [CH_NUM-1:0] v,
                        input logic [CH_NUM-1:0][SMP_W-1:0] di,
                        input logic [CH_NUM-1:0][SMP_W-1:0] dq,
                        input string tag);
        in_valid = v;
        in_i     = di;
        in_q     = dq;
        #1;
        rdy_seen = in_ready;
        model_cycle(tag);
        @(posedge clk);
        #1;
    endtask

    function automatic logic [CH_NUM-1:0][SMP_W-1:0] rnd_pair();
        logic [CH_NUM-1:0][SMP_W-1:0] r;
        for (int ch = 0; ch < CH_NUM; ch++) r[ch] = SMP_W'($urandom);
        return r;
    endfunction

    function automatic logic [CH_NUM-1:0][SMP_W-1:0] both(input int a);
        logic [CH_NUM-1:0][SMP_W-1:0] r;
        for (int ch = 0; ch < CH_NUM; ch++) r[ch] = SMP_W'(a);
        return r;
    endfunction

    // monitor: compares every cycle against the scoreboard
    always @(negedge clk) begin
        if (exp_lanes_q.size() != 0) begin
            logic [LANE_NUM-1:0][ACC_W-1:0] el;
            logic [CH_NUM-1:0] er;
            string tg;
            el = exp_lanes_q.pop_front();
            er = exp_rdy_q.pop_front();
            tg = exp_tag_q.pop_front();
            n_checks++;
            if (lane_out !== el || in_ready !== er) begin
                n_fails++;
                $display("FAIL %s lanes actual=%h expected=%h ready actual=%b expected=%b",
                         tg, lane_out, el, in_ready, er);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst        = 1'b1;
        cfg_ratio  = 4'd4;
        cfg_two_ch = 1'b0;
        route_en   = 4'b0011;
        route_lane = '{2'd3, 2'd2, 2'd1, 2'd0};
        in_valid   = '0;
        in_i       = '0;
        in_q       = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_clear();
        #1;
        chk(lane_out == '0, "R7", "reset lanes", longint'(lane_out[0]), 0);
        chk(in_ready == 2'b01, "R2", "reset ready", in_ready, 1);
        chk(in_ready[1] == 1'b0, "R3", "ch1 ready off", in_ready[1], 0);

        // R5 impulse latency and R7 sign extension
        tick(2'b01, both(100), both(-50), "R5");
        for (int n = 1; n <= 4; n++) begin
            if (n == 4) begin
                chk($signed(lane_out[0]) == 0, "R5", "lane0 before E+4", $signed(lane_out[0]), 0);
            end
            tick(2'b00, rnd_pair(), rnd_pair(), "R5");
        end
        chk($signed(lane_out[0]) == 100, "R5", "lane0 at E+4", $signed(lane_out[0]), 100);
        chk($signed(lane_out[1]) == -50, "R7", "lane1 sign ext", $signed(lane_out[1]), -50);
        repeat (30) tick({1'b0, 1'($urandom)}, rnd_pair(), rnd_pair(), "R4");

        // R8/R11 two channels, every stream on its own lane
        cfg_two_ch = 1'b1;
        route_en   = 4'b1111;
        repeat (60) tick(2'($urandom), rnd_pair(), rnd_pair(), "R11");
        chk(rdy_seen[0] == rdy_seen[1], "R11", "ready pair", rdy_seen[1], rdy_seen[0]);
        route_lane = '{2'd0, 2'd2, 2'd3, 2'd1};
        repeat (40) tick(2'b11, rnd_pair(), rnd_pair(), "R8");

        // R9 collisions, R10 unrouted lanes
        route_lane = '{2'd1, 2'd0, 2'd1, 2'd0};
        repeat (40) tick(2'b11, rnd_pair(), rnd_pair(), "R9");
        chk(lane_out[2] == '0 && lane_out[3] == '0, "R10", "unrouted lanes",
            longint'(lane_out[2]) | longint'(lane_out[3]), 0);

        // R1 ratio change with state loaded
        cfg_ratio = 4'd3;
        tick(2'b11, rnd_pair(), rnd_pair(), "R1");
        chk(rdy_seen == 2'b00, "R1", "ready in change cycle", rdy_seen, 0);
        chk(lane_out == '0, "R1", "lanes after restart", longint'(lane_out[0]), 0);
        tick(2'b00, rnd_pair(), rnd_pair(), "R2");
        chk(rdy_seen == 2'b11, "R2", "first slot after restart", rdy_seen, 3);

        // R3 channel 1 switched off while loaded
        cfg_two_ch = 1'b0;
        route_lane = '{2'd3, 2'd2, 2'd1, 2'd0};
        route_en   = 4'b1100;
        tick(2'b11, rnd_pair(), rnd_pair(), "R3");
        chk(rdy_seen[1] == 1'b0, "R3", "ch1 ready", rdy_seen[1], 0);
        chk(lane_out[2] == '0 && lane_out[3] == '0, "R3", "ch1 lanes", longint'(lane_out[2]), 0);
        repeat (10) tick(2'b11, rnd_pair(), rnd_pair(), "R3");

        // R6 DC gain at ratio 3, R2 cadence
        route_en = 4'b0001;
        repeat (60) tick(2'b01, both(200), both(0), "R6");
        chk($signed(lane_out[0]) == 200 * 27, "R6", "dc gain R=3", $signed(lane_out[0]), 200 * 27);
        cnt = 0;
        for (int n = 0; n < 30; n++) begin
            tick(2'b01, both(200), both(0), "R2");
            cnt += int'(rdy_seen[0]);
        end
        chk(cnt == 10, "R2", "slots in 30 cycles at R=3", cnt, 10);

        // R7 full precision at ratio 15
        cfg_ratio = 4'd15;
        repeat (150) tick(2'b01, both(-2048), both(0), "R7");
        chk($signed(lane_out[0]) == -2048 * 3375, "R7", "dc gain R=15",
            $signed(lane_out[0]), -2048 * 3375);

        // R12 ratio zero behaves as one
        cfg_ratio = 4'd0;
        tick(2'b01, both(77), both(0), "R12");
        cnt = 0;
        for (int n = 0; n < 20; n++) begin
            tick(2'b01, both(77), both(0), "R12");
            cnt += int'(rdy_seen[0]);
        end
        chk(cnt == 20, "R12", "ready every cycle", cnt, 20);
        chk($signed(lane_out[0]) == 77, "R12", "unity gain", $signed(lane_out[0]), 77);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule